// File: doc/BRIEF.md
# Three-Level Phase Duration Calculator

This block turns three signed phase voltage references into per-phase on-times for a three-level converter whose legs are clamped to a neutral point. It uses a terminal-voltage volt-second rule, so it needs no space-vector sector or triangle search. The level pair for each leg comes from the sign of that leg's reference alone. A strictly positive reference selects switching between the positive half-rail and neutral. Zero or a negative reference selects switching between the negative half-rail and neutral. The three sign patterns split the vector plane into six regions; for example, A positive with B and C negative is the first of them.

For each leg, the on-time is the reference magnitude times the period length, scaled by the reciprocal of the half-DC-link voltage. The reciprocal is supplied precomputed. If any leg's on-time exceeds the period, the excess is taken off all three legs. This is the same as injecting a common zero-sequence voltage, and it extends the linear range to that of conventional space-vector modulation. If the shift is larger than the smallest on-time, at least one further leg clamps, and the block raises an overmodulation flag.

The controller pulses a start strobe once per PWM period with fresh inputs. Two clock edges later the results appear on registered outputs, together with a one-cycle valid strobe. The results then hold until the next period's results arrive.

Top module: `npc_dur_calc`

## Requirements
- R1: After reset, outValid, overMod, levelPos and all three durations read 0 until the first result is produced.
- R2: levelPos bit i is 1 when the signed two's-complement reference of phase i is strictly greater than zero, and 0 otherwise. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: The raw on-time of a phase is floor(|ref| * invHalfDc * periodTicks / 2^SCALE_SHIFT), with SCALE_SHIFT = 28 by default. When no raw on-time exceeds periodTicks, each duration equals its raw on-time.
- R4: When the largest raw on-time exceeds periodTicks, the excess (largest raw minus periodTicks) is subtracted from all three raw on-times. The longest phase then reads exactly periodTicks.
- R5: Every duration is saturated to the range 0 to periodTicks. A phase whose raw on-time is not larger than the common shift reads 0.
- R6: overMod is 1 exactly when the common shift is strictly greater than the smallest of the three raw on-times. Otherwise it is 0, including when there is no shift.
- R7: outValid is high for one cycle, two clock edges after start is sampled high. Durations, levelPos and overMod hold their values until the next result.
- R8: A reference of -32768 is treated as magnitude 32768 and selects the negative pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe per PWM period; inputs are sampled with it |
| refA | input | 16 | Phase A reference, signed |
| refB | input | 16 | Phase B reference, signed |
| refC | input | 16 | Phase C reference, signed |
| invHalfDc | input | 16 | Reciprocal of half-DC-link voltage, unsigned, scaled by 2^SCALE_SHIFT |
| periodTicks | input | 16 | PWM period length in timer ticks, unsigned |
| levelPos | output | 3 | Per-phase level pair: 1 = positive/neutral, 0 = negative/neutral |
| durA | output | 16 | Phase A on-time in ticks |
| durB | output | 16 | Phase B on-time in ticks |
| durC | output | 16 | Phase C on-time in ticks |
| overMod | output | 1 | Common shift exceeded the smallest on-time |
| outValid | output | 1 | One-cycle strobe marking new results |

## Verification
The assertions check on every cycle that outValid follows start by exactly two edges and that each level bit matches the sign of the reference sampled two edges earlier. They also check that no duration exceeds the captured period, that a shifted result puts its longest phase exactly at the period, and that a flagged overmodulation always leaves at least one phase at zero. The exact on-time values need the bench's scenarios: the scaling and floor rounding, the split between linear and shifted results, the strict threshold for the overmodulation flag, the most negative reference, and holding between periods. These are compared against an independent model over random and directed inputs.

// File: rtl/npc_dur_pkg.sv
package npc_dur_pkg;
  localparam int NPH = 3;

  typedef struct packed {
    logic loadRaw;
    logic loadOut;
  } durStrobe_t;
endpackage

// File: rtl/npc_dur_ctrl.sv
module npc_dur_ctrl
  import npc_dur_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output durStrobe_t strb,
  output logic       outValid
);
  logic s1Valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= start;
      outValid <= s1Valid;
    end
  end

  always_comb begin
    strb.loadRaw = start;
    strb.loadOut = s1Valid;
  end
endmodule

// File: rtl/npc_dur_path.sv
module npc_dur_path
  import npc_dur_pkg::*;
#(
  parameter int REF_W       = 16,
  parameter int RECIP_W     = 16,
  parameter int TS_W        = 16,
  parameter int SCALE_SHIFT = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  durStrobe_t              strb,
  input  logic signed [REF_W-1:0] refIn [NPH],
  input  logic [RECIP_W-1:0]      invHalfDc,
  input  logic [TS_W-1:0]         periodTicks,
  output logic [NPH-1:0]          levelQ,
  output logic [TS_W-1:0]         durQ [NPH],
  output logic                    overQ
);
  localparam int MAG_W  = REF_W;
  localparam int PROD_W = MAG_W + RECIP_W + TS_W;
  localparam int RAW_W  = PROD_W - SCALE_SHIFT;

  logic [RAW_W-1:0] rawS1 [NPH];
  logic [NPH-1:0]   levelS1;
  logic [TS_W-1:0]  tsS1;
  logic [RAW_W-1:0] maxRaw, minRaw, shiftAmt, tsExt;
  logic [TS_W-1:0]  durNext [NPH];
  logic             overNext;

  // Stage 1: per-phase magnitude, level pair and raw on-time
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;

    always_comb begin
      mag  = refIn[p][REF_W-1] ? (~refIn[p] + 1'b1) : refIn[p];
      prod = PROD_W'(mag) * PROD_W'(invHalfDc) * PROD_W'(periodTicks);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rawS1[p]   <= '0;
        levelS1[p] <= 1'b0;
      end else if (strb.loadRaw) begin
        rawS1[p]   <= prod[SCALE_SHIFT +: RAW_W];
        levelS1[p] <= !refIn[p][REF_W-1] && (refIn[p] != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tsS1 <= '0;
    else if (strb.loadRaw) tsS1 <= periodTicks;
  end

  // Stage 2: common shift, saturation, overmodulation flag
  always_comb begin
    maxRaw = rawS1[0];
    minRaw = rawS1[0];
    for (int p = 1; p < NPH; p++) begin
      if (rawS1[p] > maxRaw) maxRaw = rawS1[p];
      if (rawS1[p] < minRaw) minRaw = rawS1[p];
    end
    tsExt    = RAW_W'(tsS1);
    shiftAmt = (maxRaw > tsExt) ? (maxRaw - tsExt) : '0;
    overNext = shiftAmt > minRaw;
    for (int p = 0; p < NPH; p++) begin
      logic [RAW_W-1:0] adj;
      adj = (rawS1[p] > shiftAmt) ? (rawS1[p] - shiftAmt) : '0;
      durNext[p] = (adj > tsExt) ? tsS1 : adj[TS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      levelQ <= '0;
      overQ  <= 1'b0;
      for (int p = 0; p < NPH; p++) durQ[p] <= '0;
    end else if (strb.loadOut) begin
      levelQ <= levelS1;
      overQ  <= overNext;
      for (int p = 0; p < NPH; p++) durQ[p] <= durNext[p];
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    // R5: no registered duration exceeds the period it was computed for
    a_r5_dur_within_ts: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strb.loadOut) |-> durQ[p] <= $past(tsS1));
  end

  // R4: a shifted result places its longest phase exactly at the period
  a_r4_peak_at_ts: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strb.loadOut) && $past(maxRaw > RAW_W'(tsS1))) |->
      (durQ[0] == $past(tsS1) || durQ[1] == $past(tsS1) || durQ[2] == $past(tsS1)));

  // R6: a flagged overmodulation always leaves some phase at zero
  a_r6_over_has_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strb.loadOut) && overQ) |->
      (durQ[0] == '0 || durQ[1] == '0 || durQ[2] == '0));
endmodule

// File: rtl/npc_dur_calc.sv
module npc_dur_calc
  import npc_dur_pkg::*;
#(
  parameter int REF_W       = 16,
  parameter int RECIP_W     = 16,
  parameter int TS_W        = 16,
  parameter int SCALE_SHIFT = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [REF_W-1:0] refA,
  input  logic signed [REF_W-1:0] refB,
  input  logic signed [REF_W-1:0] refC,
  input  logic [RECIP_W-1:0]      invHalfDc,
  input  logic [TS_W-1:0]         periodTicks,
  output logic [NPH-1:0]          levelPos,
  output logic [TS_W-1:0]         durA,
  output logic [TS_W-1:0]         durB,
  output logic [TS_W-1:0]         durC,
  output logic                    overMod,
  output logic                    outValid
);
  durStrobe_t              strb;
  logic signed [REF_W-1:0] refArr [NPH];
  logic [TS_W-1:0]         durArr [NPH];

  always_comb begin
    refArr[0] = refA;
    refArr[1] = refB;
    refArr[2] = refC;
  end

  npc_dur_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .strb(strb), .outValid(outValid)
  );

  npc_dur_path #(
    .REF_W(REF_W), .RECIP_W(RECIP_W), .TS_W(TS_W), .SCALE_SHIFT(SCALE_SHIFT)
  ) path_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .refIn(refArr),
    .invHalfDc(invHalfDc), .periodTicks(periodTicks),
    .levelQ(levelPos), .durQ(durArr), .overQ(overMod)
  );

  assign durA = durArr[0];
  assign durB = durArr[1];
  assign durC = durArr[2];

  // R7: a result strobe is always two edges after a start
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(start, 2));

  // R2: level pair follows the sign of the reference sampled with start
  a_r2_level_sign: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (levelPos[0] == ($past(refA, 2) > 0) &&
                  levelPos[1] == ($past(refB, 2) > 0) &&
                  levelPos[2] == ($past(refC, 2) > 0)));
endmodule

// File: tb/npc_dur_calc_tb_top.sv
module npc_dur_calc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] refA = '0, refB = '0, refC = '0;
  logic [15:0] invHalfDc = '0, periodTicks = '0;
  logic [2:0]  levelPos;
  logic [15:0] durA, durB, durC;
  logic        overMod, outValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  npc_dur_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .refA(refA), .refB(refB), .refC(refC),
    .invHalfDc(invHalfDc), .periodTicks(periodTicks), .levelPos(levelPos),
    .durA(durA), .durB(durB), .durC(durC), .overMod(overMod), .outValid(outValid)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint rawOf(int r, int k, int ts);
    longint mag;
    mag = (r < 0) ? -longint'(r) : longint'(r);
    return (mag * longint'(k) * longint'(ts)) >>> 28;
  endfunction

  longint expDur [3];
  bit     expOver;
  bit     expShifted;

  task automatic model(int ra, int rb, int rc, int k, int ts);
    longint raw [3];
    longint mx, mn, sh, d;
    raw[0] = rawOf(ra, k, ts);
    raw[1] = rawOf(rb, k, ts);
    raw[2] = rawOf(rc, k, ts);
    mx = raw[0]; mn = raw[0];
    for (int i = 1; i < 3; i++) begin
      if (raw[i] > mx) mx = raw[i];
      if (raw[i] < mn) mn = raw[i];
    end
    sh = (mx > ts) ? mx - ts : 0;
    expShifted = sh > 0;
    expOver = sh > mn;
    for (int i = 0; i < 3; i++) begin
      d = raw[i] - sh;
      if (d < 0) d = 0;
      if (d > ts) d = ts;
      expDur[i] = d;
    end
  endtask

  task automatic runVec(int ra, int rb, int rc, int k, int ts, string tag);
    string dreq;
    @(negedge clk);
    refA = 16'(ra); refB = 16'(rb); refC = 16'(rc);
    invHalfDc = 16'(k); periodTicks = 16'(ts); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    refA = '0; refB = '0; refC = '0;
    @(negedge clk);
    model(ra, rb, rc, k, ts);
    dreq = expShifted ? "R4/R5" : "R3";
    check("R7", {tag, " valid"}, outValid, 1);
    check("R2", {tag, " levelA"}, levelPos[0], ra > 0);
    check("R2", {tag, " levelB"}, levelPos[1], rb > 0);
    check("R2", {tag, " levelC"}, levelPos[2], rc > 0);
    check(dreq, {tag, " durA"}, durA, expDur[0]);
    check(dreq, {tag, " durB"}, durB, expDur[1]);
    check(dreq, {tag, " durC"}, durC, expDur[2]);
    check("R6", {tag, " overMod"}, overMod, expOver);
    @(negedge clk);
    check("R7", {tag, " valid drop"}, outValid, 0);
    check("R7", {tag, " hold durA"}, durA, expDur[0]);
  endtask

  initial begin
    int ra, rb, rc, k, ts;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid", outValid, 0);
    check("R1", "overMod", overMod, 0);
    check("R1", "levelPos", levelPos, 0);
    check("R1", "durA", durA, 0);
    check("R1", "durB", durB, 0);
    check("R1", "durC", durC, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle valid", outValid, 0);

    // R3: sector with A positive, B and C negative, linear
    runVec(4000, -2000, -2000, 32768, 1000, "R3 linear");
    // R2: zero reference selects negative pair, zero duration
    runVec(0, 0, 0, 32768, 1000, "R2 zero");
    // R4: exact boundary, largest raw equals period, no shift
    runVec(8192, -4096, 100, 32768, 1000, "R4 boundary");
    // R4: moderate overshoot, still linear
    runVec(9000, -2000, -3000, 32768, 1000, "R4 shift");
    // R5/R6: shift equals smallest raw, not overmodulated
    runVec(9000, 808, 4000, 32768, 1000, "R6 equal");
    // R6: deep overshoot, overmodulated
    runVec(16000, -100, -200, 32768, 1000, "R6 over");
    // R8: most negative reference
    runVec(-32768, 1000, 1000, 16384, 2000, "R8 minneg");
    runVec(32767, -32768, 0, 65535, 65535, "R8 extreme");

    for (int n = 0; n < 300; n++) begin
      ra = int'($urandom_range(0, 65535)) - 32768;
      rb = int'($urandom_range(0, 65535)) - 32768;
      rc = int'($urandom_range(0, 65535)) - 32768;
      k  = int'($urandom_range(4096, 49151));
      ts = int'($urandom_range(100, 5000));
      runVec(ra, rb, rc, k, ts, "rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule